// File: doc/BRIEF.md
# Device Startup Phase Sequencer

This block runs once the configuration data of a programmable device has finished loading. Its input `go` signals that loading is complete. It then steps a 3-bit phase counter forward on the startup clock, and four one-shot events fire as the counter passes programmable phase numbers:

- The open-drain completion pin is released.
- The global I/O tri-state is lifted.
- Global writes to storage elements are enabled.
- End of startup is flagged.

Each event stays latched until a synchronous reset. Two optional waits can hold the counter at a chosen phase until the clock-manager lock input and the impedance-calibration match input are true. This keeps pin release, I/O enable and write enable from happening too early.

The completion pin may be held low by another device so that several devices start together. For this reason the sequencer tests the pin level it samples back, after a two-flop synchronizer, and does not rely only on its own release flag. The two values are reported separately in a packed status vector that a status register can read. There is no data stream through the block, so every port is plain control or status.

Top module: `startup_seq`

## Requirements
- R1: A synchronous reset sets the phase to 0, asserts tri-state (`gts`=1), deasserts write enable (`gwe`=0), clears end-of-startup and the release flag, and drives the pin low (`pin_oe`=1, `pin_o`=0).
- R2: While `go` is high and no hold applies, the phase counter advances by exactly one per clock. It holds while `go` is low.
- R3: When the sequencer advances while at the phase given by an event's configuration input, that event takes effect on the next clock and stays in effect until reset. The four events are: release flag set, `gts` cleared, `gwe` set, `eos` set.
- R4: Once the pin is released, `pin_oe`=0 (high impedance) when `cfg_drive_high`=0. When `cfg_drive_high`=1 it is instead `pin_oe`=1 with `pin_o`=1.
- R5: While the release flag is set and the synchronized pin level is low, the phase holds. The synchronizer adds two clocks of latency from `pin_in` to the tested level.
- R6: With `cfg_lock_wait`=1, the sequencer does not advance from phase `cfg_wait_phase` while `lock_in` is low.
- R7: With `cfg_match_wait`=1, the sequencer does not advance from phase `cfg_wait_phase` while `match_in` is low.
- R8: The counter does not increment from the end-of-startup phase. Once `eos` is set, the phase stays constant until reset.
- R9: `status` bit positions are: 0 release flag, 1 synchronized pin level, 2 `gwe`, 3 `gts`, 4 `eos`, 5 `match_in`, 6 `lock_in`.
- R10: The release flag (status bit 0) reads 1 while the synchronized pin level (status bit 1) reads 0 if the pin is held low externally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Startup clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Configuration loaded; enables stepping |
| cfg_rel_phase | input | 3 | Phase at which the pin is released |
| cfg_tris_phase | input | 3 | Phase at which tri-state is lifted |
| cfg_wen_phase | input | 3 | Phase at which write enable is asserted |
| cfg_eos_phase | input | 3 | Phase at which end-of-startup is asserted |
| cfg_wait_phase | input | 3 | Phase at which the lock/match waits are tested |
| cfg_lock_wait | input | 1 | Enable wait on `lock_in` |
| cfg_match_wait | input | 1 | Enable wait on `match_in` |
| cfg_drive_high | input | 1 | Drive the released pin high instead of floating it |
| lock_in | input | 1 | Clock managers locked |
| match_in | input | 1 | Impedance calibration matched |
| pin_in | input | 1 | Sampled level of the completion pin |
| pin_oe | output | 1 | Pin output enable |
| pin_o | output | 1 | Pin output value |
| gts | output | 1 | Global tri-state, active high |
| gwe | output | 1 | Global write enable |
| eos | output | 1 | End of startup |
| phase | output | 3 | Current phase counter |
| status | output | 7 | Packed status bits, order per R9 |

## Verification
The sequence is run in several configurations:
- The default event phases 4/5/6/7 show the basic ordering.
- A compressed order with drive-high enabled separates the two pin-drive modes and shows that event phases are really programmable.
- An external hold-low of the pin separates the release flag from the sampled level and exposes the two-clock synchronizer latency.

The lock and match waits are tried one at a time, so a wait that is ignored, or that is tied to the wrong input, shows up as an early advance. Toggling `go` mid-run and resetting after end of startup show that the counter holds and that all latched events clear.

// File: rtl/startup_pkg.sv
package startup_pkg;
  localparam int PHASE_W = 3;
  localparam int NUM_EV  = 4;
  localparam int EV_REL  = 0;
  localparam int EV_TRIS = 1;
  localparam int EV_WEN  = 2;
  localparam int EV_EOS  = 3;

  typedef struct packed {
    logic lock;
    logic match;
    logic eos;
    logic gts;
    logic gwe;
    logic pin;
    logic rel;
  } status_t;
endpackage

// File: rtl/stsq_sync.sv
module stsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/stsq_phase_ctr.sv
module stsq_phase_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] stop_at,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (step && cnt != stop_at) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stsq_evt_latch.sv
module stsq_evt_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] at,
  output logic         fired
);
  always_ff @(posedge clk) begin
    if (rst)                     fired <= 1'b0;
    else if (step && cur == at)  fired <= 1'b1;
  end
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int PW          = PHASE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [PW-1:0] cfg_rel_phase,
  input  logic [PW-1:0] cfg_tris_phase,
  input  logic [PW-1:0] cfg_wen_phase,
  input  logic [PW-1:0] cfg_eos_phase,
  input  logic [PW-1:0] cfg_wait_phase,
  input  logic          cfg_lock_wait,
  input  logic          cfg_match_wait,
  input  logic          cfg_drive_high,
  input  logic          lock_in,
  input  logic          match_in,
  input  logic          pin_in,
  output logic          pin_oe,
  output logic          pin_o,
  output logic          gts,
  output logic          gwe,
  output logic          eos,
  output logic [PW-1:0] phase,
  output logic [6:0]    status
);
  logic [NUM_EV-1:0][PW-1:0] ev_at;
  logic [NUM_EV-1:0]         ev_hit;
  logic                      pin_s;
  logic                      wait_hold;
  logic                      pin_hold;
  logic                      step;
  status_t                   st;

  assign ev_at[EV_REL]  = cfg_rel_phase;
  assign ev_at[EV_TRIS] = cfg_tris_phase;
  assign ev_at[EV_WEN]  = cfg_wen_phase;
  assign ev_at[EV_EOS]  = cfg_eos_phase;

  stsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  // Holds: gated waits at the chosen phase, released pin still low, finished.
  assign wait_hold = (phase == cfg_wait_phase) &&
                     ((cfg_lock_wait && !lock_in) || (cfg_match_wait && !match_in));
  assign pin_hold  = ev_hit[EV_REL] && !pin_s;
  assign step      = go && !wait_hold && !pin_hold && !ev_hit[EV_EOS];

  stsq_phase_ctr #(.W(PW)) u_ctr (
    .clk(clk), .rst(rst), .step(step), .stop_at(cfg_eos_phase), .cnt(phase)
  );

  generate
    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
      stsq_evt_latch #(.W(PW)) u_ev (
        .clk(clk), .rst(rst), .step(step), .cur(phase), .at(ev_at[i]),
        .fired(ev_hit[i])
      );
    end
  endgenerate

  assign gts    = !ev_hit[EV_TRIS];
  assign gwe    = ev_hit[EV_WEN];
  assign eos    = ev_hit[EV_EOS];
  assign pin_oe = !ev_hit[EV_REL] || cfg_drive_high;
  assign pin_o  = ev_hit[EV_REL];

  always_comb begin
    st.rel   = ev_hit[EV_REL];
    st.pin   = pin_s;
    st.gwe   = gwe;
    st.gts   = gts;
    st.eos   = eos;
    st.match = match_in;
    st.lock  = lock_in;
  end
  assign status = st;
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic [PW-1:0] cfg_wait_phase,
  input logic          cfg_lock_wait,
  input logic          cfg_match_wait,
  input logic          cfg_drive_high,
  input logic          lock_in,
  input logic          match_in,
  input logic          pin_oe,
  input logic          gts,
  input logic          gwe,
  input logic          eos,
  input logic [PW-1:0] phase,
  input logic [6:0]    status
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (phase == '0 && gts && !gwe && !eos && !status[0] && pin_oe));
  // R2
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase == $past(phase) || phase == $past(phase) + 1'b1));
  a_r2_go_low_holds: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(phase));
  // R3
  a_r3_gwe_sticky: assert property (@(posedge clk) disable iff (rst)
    gwe |=> gwe);
  a_r3_gts_sticky: assert property (@(posedge clk) disable iff (rst)
    !gts |=> !gts);
  // R4
  a_r4_hiz_release: assert property (@(posedge clk) disable iff (rst)
    (status[0] && !cfg_drive_high) |-> !pin_oe);
  // R5
  a_r5_pin_hold: assert property (@(posedge clk) disable iff (rst)
    (status[0] && !status[1]) |=> $stable(phase));
  // R6
  a_r6_lock_wait: assert property (@(posedge clk) disable iff (rst)
    (cfg_lock_wait && !lock_in && phase == cfg_wait_phase) |=> $stable(phase));
  // R7
  a_r7_match_wait: assert property (@(posedge clk) disable iff (rst)
    (cfg_match_wait && !match_in && phase == cfg_wait_phase) |=> $stable(phase));
  // R8
  a_r8_eos_final: assert property (@(posedge clk) disable iff (rst)
    eos |=> (eos && $stable(phase)));
endmodule

bind startup_seq startup_seq_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .go(go), .cfg_wait_phase(cfg_wait_phase),
  .cfg_lock_wait(cfg_lock_wait), .cfg_match_wait(cfg_match_wait),
  .cfg_drive_high(cfg_drive_high), .lock_in(lock_in), .match_in(match_in),
  .pin_oe(pin_oe), .gts(gts), .gwe(gwe), .eos(eos), .phase(phase),
  .status(status)
);

// File: tb/startup_seq_tb.sv
module startup_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [2:0] c_rel = 3'd4, c_tris = 3'd5, c_wen = 3'd6, c_eos = 3'd7, c_wait = 3'd0;
  logic c_lw = 1'b0, c_mw = 1'b0, c_dh = 1'b0;
  logic lock_in = 1'b0, match_in = 1'b0, pin_in = 1'b0;
  logic ext_hold = 1'b0;
  logic pin_oe, pin_o, gts, gwe, eos;
  logic [2:0] phase;
  logic [6:0] status;

  int vectors = 0, errors = 0, cyc = 0;

  // reference model state
  int m_ph = 0, m_s1 = 0, m_s2 = 0;
  bit m_rel = 0, m_tris = 0, m_wen = 0, m_eos = 0;

  always #10 clk = ~clk;

  startup_seq u_dut (
    .clk(clk), .rst(rst), .go(go),
    .cfg_rel_phase(c_rel), .cfg_tris_phase(c_tris), .cfg_wen_phase(c_wen),
    .cfg_eos_phase(c_eos), .cfg_wait_phase(c_wait),
    .cfg_lock_wait(c_lw), .cfg_match_wait(c_mw), .cfg_drive_high(c_dh),
    .lock_in(lock_in), .match_in(match_in), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_o(pin_o), .gts(gts), .gwe(gwe), .eos(eos),
    .phase(phase), .status(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // model step at each edge, then compare all outputs 5 ns later
  always @(posedge clk) begin
    bit wst, pst, adv;
    cyc++;
    if (rst) begin
      m_ph = 0; m_s1 = 0; m_s2 = 0;
      m_rel = 0; m_tris = 0; m_wen = 0; m_eos = 0;
    end else begin
      wst = (m_ph == int'(c_wait)) && ((c_lw && !lock_in) || (c_mw && !match_in));
      pst = m_rel && (m_s2 == 0);
      adv = go && !wst && !pst && !m_eos;
      if (adv) begin
        if (m_ph == int'(c_rel))  m_rel  = 1;
        if (m_ph == int'(c_tris)) m_tris = 1;
        if (m_ph == int'(c_wen))  m_wen  = 1;
        if (m_ph == int'(c_eos))  m_eos  = 1;
        if (m_ph != int'(c_eos))  m_ph = (m_ph + 1) % 8;
      end
      m_s2 = m_s1;
      m_s1 = int'(pin_in);
    end
    #5;
    chk("R2 phase", int'(phase), m_ph);
    chk("R3 gts", int'(gts), int'(!m_tris));
    chk("R3 gwe", int'(gwe), int'(m_wen));
    chk("R8 eos", int'(eos), int'(m_eos));
    chk("R4 pin_oe", int'(pin_oe), int'(!m_rel || c_dh));
    chk("R4 pin_o", int'(pin_o), int'(m_rel));
    chk("R9 status", int'(status),
        int'({lock_in, match_in, m_eos, !m_tris, m_wen, m_s2[0], m_rel}));
  end

  // external pull-up model: pin high once released unless another device holds it
  always @(negedge clk) pin_in <= !ext_hold && m_rel;

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; go = 1'b0;
    cycles(2); rst = 1'b0;
  endtask

  initial begin
    // R1: reset state
    cycles(3);
    rst = 1'b0;
    chk("R1 phase", int'(phase), 0);
    chk("R1 gts", int'(gts), 1);
    chk("R1 pin_oe", int'(pin_oe), 1);
    chk("R1 pin_o", int'(pin_o), 0);

    // default order 4/5/6/7, floating release (R2, R3, R4, R8)
    go = 1'b1;
    cycles(25);
    chk("R8 eos final", int'(eos), 1);
    chk("R8 phase at eos", int'(phase), 7);
    chk("R4 floating", int'(pin_oe), 0);

    // R1 after completion
    do_reset();
    chk("R1 eos cleared", int'(eos), 0);
    chk("R1 gwe cleared", int'(gwe), 0);

    // R5 / R10: pin held low by another device
    ext_hold = 1'b1; go = 1'b1;
    cycles(15);
    chk("R5 held phase", int'(phase), 5);
    chk("R10 rel flag", int'(status[0]), 1);
    chk("R10 pin level", int'(status[1]), 0);
    ext_hold = 1'b0;
    cycles(2);
    chk("R5 sync latency", int'(phase), 5);
    cycles(10);
    chk("R5 resumed", int'(eos), 1);

    // R6: lock wait at phase 2
    do_reset();
    c_wait = 3'd2; c_lw = 1'b1; lock_in = 1'b0; match_in = 1'b0; go = 1'b1;
    cycles(10);
    chk("R6 lock wait phase", int'(phase), 2);
    chk("R6 no release", int'(status[0]), 0);
    lock_in = 1'b1;
    cycles(12);
    chk("R6 finished", int'(eos), 1);

    // R7: match wait at phase 3
    do_reset();
    c_lw = 1'b0; c_mw = 1'b1; c_wait = 3'd3; match_in = 1'b0; lock_in = 1'b0;
    go = 1'b1;
    cycles(10);
    chk("R7 match wait phase", int'(phase), 3);
    chk("R7 gts still set", int'(gts), 1);
    match_in = 1'b1;
    cycles(12);
    chk("R7 finished", int'(eos), 1);

    // R3/R4: compressed order with active drive, go toggled (R2)
    do_reset();
    c_mw = 1'b0; c_rel = 3'd1; c_tris = 3'd2; c_wen = 3'd3; c_eos = 3'd5;
    c_dh = 1'b1; go = 1'b1;
    cycles(2);
    go = 1'b0;
    cycles(4);
    chk("R2 go low hold", int'(phase), 2);
    go = 1'b1;
    cycles(15);
    chk("R4 drive high oe", int'(pin_oe), 1);
    chk("R4 drive high o", int'(pin_o), 1);
    chk("R8 custom eos phase", int'(phase), 5);
    chk("R3 gwe on", int'(gwe), 1);

    cycles(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule